// File: doc/BRIEF.md
# Clock synchronizer mode controller

This block decides which of three operating modes a digital PLL runs in: Holdover, where the loop coasts on its last frequency; TIE correction, where the loop re-acquires a reference while keeping the phase the outputs already have; and Normal, where the loop tracks the selected reference. It watches a flag that reports the selected reference as disrupted. It also watches a two-bit reference select, a one-cycle pulse from an automatic reference-switching machine, and a hitless control bit.

On recovery from Holdover the hitless bit chooses between two paths. One path realigns the outputs to the reference phase through a one-cycle command. The other path captures the current signed phase error into an offset register, which the loop subtracts so that the existing output phase is kept. Any change of reference forces the phase-keeping path, whatever the hitless bit says. The loop filter, the oscillator and reference frequency detection are outside the block.

Top module: `clk_sync_mode_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, mode is 2'b00 (Holdover), holdover is 1, realign is 0 and phase_ofs is 0. Reset is synchronous and active high.
- R2: In Holdover with ref_bad = 1, the controller stays in Holdover at the next clock.
- R3: In Holdover with ref_bad = 0, hitless = 0 and no reference change pending, the next mode is 2'b10 (Normal). In that first Normal cycle realign is 1 for exactly one cycle, and phase_ofs is cleared to 0.
- R4: In Holdover with ref_bad = 0 and hitless = 1, the next mode is 2'b01 (TIE correction), and phase_ofs takes the phase_err value that was present before that clock edge.
- R5: A reference change is a ref_sel value that differs from its value in the previous cycle, or auto_sw_pulse = 1. A change seen in Normal or TIE correction gives Holdover at the next clock. A change stays pending until TIE correction is entered, so the next recovery goes to TIE correction even with hitless = 0. A change seen in Holdover while ref_bad = 0 also sends the controller to TIE correction.
- R6: In Normal or TIE correction, ref_bad = 1 gives Holdover at the next clock. This takes priority over the end of TIE correction.
- R7: TIE correction lasts TIE_CYCLES clock cycles without disruption or change, then mode becomes Normal. phase_ofs keeps the captured value throughout TIE correction and in the Normal mode that follows.
- R8: holdover is 1 whenever mode is Holdover or TIE correction and 0 only in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_bad | input | 1 | Selected reference is disrupted |
| ref_sel | input | 2 | Reference select; any change of value counts as a reference change |
| auto_sw_pulse | input | 1 | One-cycle pulse from the automatic reference-switch machine |
| hitless | input | 1 | 1 selects phase-keeping recovery, 0 selects realign |
| phase_err | input | PHASE_W | Signed output-to-reference phase error sample |
| mode | output | 2 | 00 Holdover, 01 TIE correction, 10 Normal |
| holdover | output | 1 | 1 unless the mode is Normal |
| realign | output | 1 | One-cycle command to snap the outputs to the reference phase |
| phase_ofs | output | PHASE_W | Stored signed phase offset for the loop to subtract |

## Verification
The assertions assume that every input is synchronous to clk. They also assume that the automatic switch pulse is a single cycle wide, and that phase_err is a valid sample in every cycle, since it may be captured at any Holdover exit. The bench changes inputs only on the falling edge and drives the switch pulse for one cycle at a time. It runs a small configuration with TIE_CYCLES = 4, so that both the full TIE window and its aborts are reached many times. A long pseudo-random sweep mixes disruptions, select changes and pulses at rates that let all three modes and every transition occur.

// File: rtl/csm_pkg.sv
package csm_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_TIE  = 2'b01,
        MODE_NORM = 2'b10
    } mode_e;

    typedef struct packed {
        logic bad;
        logic hitless;
        logic chg_now;
        logic pend_eff;
    } fsm_in_t;

    function automatic logic mode_is_holdover(mode_e m);
        return (m != MODE_NORM);
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/csm_ref_change.sv
module csm_ref_change #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] ref_sel,
    input  logic             auto_pulse,
    input  logic             consume,
    output logic             chg_now,
    output logic             pend_eff
);
    logic [SEL_W-1:0] sel_q;
    logic             pend_q;

    assign chg_now  = (ref_sel != sel_q) || auto_pulse;
    assign pend_eff = pend_q || chg_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= ref_sel;
            pend_q <= 1'b0;
        end else begin
            sel_q  <= ref_sel;
            pend_q <= consume ? 1'b0 : pend_eff;
        end
    end

    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !consume) |=> pend_q); // R5

    AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        consume |=> !pend_q); // R5

endmodule

// File: rtl/csm_mode_fsm.sv
module csm_mode_fsm
    import csm_pkg::*;
#(
    parameter int unsigned TIE_CYCLES = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  fsm_in_t fin,
    output mode_e   state,
    output logic    tie_entry,
    output logic    direct_entry,
    output logic    realign
);
    localparam int unsigned CNT_W = cnt_width(TIE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIE_CYCLES - 1);

    mode_e            nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             realign_q;

    always_comb begin
        nxt          = state;
        tie_entry    = 1'b0;
        direct_entry = 1'b0;
        case (state)
            MODE_HOLD: begin
                if (!fin.bad) begin
                    if (fin.hitless || fin.pend_eff) begin
                        nxt       = MODE_TIE;
                        tie_entry = 1'b1;
                    end else begin
                        nxt          = MODE_NORM;
                        direct_entry = 1'b1;
                    end
                end
            end
            MODE_TIE: begin
                if (fin.bad || fin.chg_now)
                    nxt = MODE_HOLD;
                else if (cnt_q == CNT_LAST)
                    nxt = MODE_NORM;
            end
            MODE_NORM: begin
                if (fin.bad || fin.chg_now)
                    nxt = MODE_HOLD;
            end
            default: nxt = MODE_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= MODE_HOLD;
            cnt_q     <= '0;
            realign_q <= 1'b0;
        end else begin
            state     <= nxt;
            realign_q <= direct_entry;
            if (tie_entry)
                cnt_q <= '0;
            else if (state == MODE_TIE)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign realign = realign_q;

    AST_HOLD_WHILE_BAD: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_HOLD && fin.bad) |=> state == MODE_HOLD); // R2

    AST_BAD_FORCES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != MODE_HOLD && fin.bad) |=> state == MODE_HOLD); // R6

    AST_CHANGE_FORCES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != MODE_HOLD && fin.chg_now) |=> state == MODE_HOLD); // R5

    AST_PENDING_GOES_TIE: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_HOLD && !fin.bad && fin.pend_eff) |=> state == MODE_TIE); // R5

    AST_REALIGN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        realign |=> !realign); // R3

    AST_REALIGN_IN_NORMAL: assert property (@(posedge clk) disable iff (rst)
        realign |-> (state == MODE_NORM && $past(state) == MODE_HOLD)); // R3

    AST_NORMAL_FROM_TIE_AT_END: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_NORM && $past(state) == MODE_TIE) |-> $past(cnt_q) == CNT_LAST); // R7

    AST_LEGAL_MODE: assert property (@(posedge clk) disable iff (rst)
        state inside {MODE_HOLD, MODE_TIE, MODE_NORM}); // R8

endmodule

// File: rtl/csm_phase_hold.sv
module csm_phase_hold #(
    parameter int unsigned PHASE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      capture,
    input  logic                      clear,
    input  logic signed [PHASE_W-1:0] phase_err,
    output logic signed [PHASE_W-1:0] ofs
);
    always_ff @(posedge clk) begin
        if (rst)
            ofs <= '0;
        else if (capture)
            ofs <= phase_err;
        else if (clear)
            ofs <= '0;
    end

    AST_CAPTURE_TAKES_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        capture |=> ofs == $past(phase_err)); // R4

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (clear && !capture) |=> ofs == '0); // R3

endmodule

// File: rtl/clk_sync_mode_ctrl.sv
module clk_sync_mode_ctrl
    import csm_pkg::*;
#(
    parameter int unsigned PHASE_W    = 16,
    parameter int unsigned SEL_W      = 2,
    parameter int unsigned TIE_CYCLES = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ref_bad,
    input  logic [SEL_W-1:0]          ref_sel,
    input  logic                      auto_sw_pulse,
    input  logic                      hitless,
    input  logic signed [PHASE_W-1:0] phase_err,
    output logic [1:0]                mode,
    output logic                      holdover,
    output logic                      realign,
    output logic signed [PHASE_W-1:0] phase_ofs
);
    logic    chg_now;
    logic    pend_eff;
    logic    tie_entry;
    logic    direct_entry;
    mode_e   state;
    fsm_in_t fin;

    csm_ref_change #(.SEL_W(SEL_W)) u_chg (
        .clk        (clk),
        .rst        (rst),
        .ref_sel    (ref_sel),
        .auto_pulse (auto_sw_pulse),
        .consume    (tie_entry),
        .chg_now    (chg_now),
        .pend_eff   (pend_eff)
    );

    always_comb begin
        fin.bad      = ref_bad;
        fin.hitless  = hitless;
        fin.chg_now  = chg_now;
        fin.pend_eff = pend_eff;
    end

    csm_mode_fsm #(.TIE_CYCLES(TIE_CYCLES)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .fin          (fin),
        .state        (state),
        .tie_entry    (tie_entry),
        .direct_entry (direct_entry),
        .realign      (realign)
    );

    csm_phase_hold #(.PHASE_W(PHASE_W)) u_ofs (
        .clk       (clk),
        .rst       (rst),
        .capture   (tie_entry),
        .clear     (direct_entry),
        .phase_err (phase_err),
        .ofs       (phase_ofs)
    );

    assign mode     = state;
    assign holdover = mode_is_holdover(state);

    AST_OFS_STABLE_IN_TIE: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_TIE && $past(state) == MODE_TIE) |-> $stable(phase_ofs)); // R7

    AST_REALIGN_ONLY_OUT_OF_HOLDOVER: assert property (@(posedge clk) disable iff (rst)
        realign |-> !holdover); // R8

endmodule

// File: tb/clk_sync_mode_ctrl_tb.sv
`timescale 1ns/1ps
module clk_sync_mode_ctrl_tb;
    localparam int PW = 16;
    localparam int NT = 4;
    localparam logic [1:0] M_HOLD = 2'b00, M_TIE = 2'b01, M_NORM = 2'b10;

    logic clk = 1'b0;
    logic rst, ref_bad, auto_sw_pulse, hitless;
    logic [1:0] ref_sel;
    logic signed [PW-1:0] phase_err;
    logic [1:0] mode;
    logic holdover, realign;
    logic signed [PW-1:0] phase_ofs;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    logic [1:0] m_mode, m_prevsel;
    logic m_pend, m_real;
    int m_cnt;
    logic signed [PW-1:0] m_ofs;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    clk_sync_mode_ctrl #(.PHASE_W(PW), .SEL_W(2), .TIE_CYCLES(NT)) u_dut (
        .clk(clk), .rst(rst), .ref_bad(ref_bad), .ref_sel(ref_sel),
        .auto_sw_pulse(auto_sw_pulse), .hitless(hitless), .phase_err(phase_err),
        .mode(mode), .holdover(holdover), .realign(realign), .phase_ofs(phase_ofs)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "mode", int'(mode), int'(m_mode));
        chk("R8", "holdover", int'(holdover), int'(m_mode != M_NORM));
        chk(tag, "realign", int'(realign), int'(m_real));
        chk(tag, "phase_ofs", int'(phase_ofs), int'(m_ofs));
    endtask

    task automatic model_next(input logic b, input logic [1:0] s, input logic a,
                              input logic h, input logic signed [PW-1:0] pe);
        logic chg, pe_flag;
        chg = (s != m_prevsel) || a;
        pe_flag = m_pend || chg;
        m_real = 1'b0;
        m_prevsel = s;
        case (m_mode)
            M_HOLD: begin
                if (!b && (h || pe_flag)) begin
                    m_mode = M_TIE; m_cnt = 0; m_ofs = pe; m_pend = 1'b0;
                end else if (!b) begin
                    m_mode = M_NORM; m_real = 1'b1; m_ofs = '0; m_pend = 1'b0;
                end else m_pend = pe_flag;
            end
            M_TIE: begin
                m_pend = pe_flag;
                if (b || chg) m_mode = M_HOLD;
                else if (m_cnt == NT - 1) m_mode = M_NORM;
                else m_cnt++;
            end
            default: begin
                m_pend = pe_flag;
                if (b || chg) m_mode = M_HOLD;
            end
        endcase
    endtask

    task automatic step(input logic b, input logic [1:0] s, input logic a, input logic h,
                        input logic signed [PW-1:0] pe, input string tag);
        ref_bad = b; ref_sel = s; auto_sw_pulse = a; hitless = h; phase_err = pe;
        model_next(b, s, a, h, pe);
        @(posedge clk);
        #1;
        compare(tag);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; ref_bad = 1'b1; ref_sel = 2'd0; auto_sw_pulse = 1'b0;
        hitless = 1'b0; phase_err = 16'sd99;
        m_mode = M_HOLD; m_prevsel = 2'd0; m_pend = 1'b0; m_real = 1'b0;
        m_cnt = 0; m_ofs = '0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1");
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 2'd0, 1'b0, 1'b0, 16'sd5, "R1");
        chk("R1", "mode literal", int'(mode), 0);
        step(1'b1, 2'd0, 1'b0, 1'b0, 16'sd6, "R2");
        step(1'b1, 2'd0, 1'b0, 1'b1, 16'sd7, "R2");
        step(1'b0, 2'd0, 1'b0, 1'b0, 16'sd8, "R3");
        chk("R3", "direct normal", int'(mode), 2);
        chk("R3", "realign high", int'(realign), 1);
        step(1'b0, 2'd0, 1'b0, 1'b0, 16'sd9, "R3");
        chk("R3", "realign single", int'(realign), 0);
        step(1'b1, 2'd0, 1'b0, 1'b0, 16'sd9, "R6");
        step(1'b0, 2'd0, 1'b0, 1'b1, -16'sd123, "R4");
        chk("R4", "captured", int'(phase_ofs), -123);
        for (int i = 0; i < NT; i++) step(1'b0, 2'd0, 1'b0, 1'b0, 16'sd55, "R7");
        chk("R7", "after tie", int'(mode), 2);
        chk("R7", "ofs kept", int'(phase_ofs), -123);
        step(1'b0, 2'd1, 1'b0, 1'b0, 16'sd70, "R5");
        step(1'b0, 2'd1, 1'b0, 1'b0, 16'sd77, "R5");
        chk("R5", "pending forces tie", int'(mode), 1);
        step(1'b1, 2'd1, 1'b0, 1'b0, 16'sd1, "R6");
        step(1'b0, 2'd1, 1'b0, 1'b0, 16'sd2, "R3");
        step(1'b0, 2'd1, 1'b1, 1'b0, 16'sd3, "R5");
        step(1'b0, 2'd1, 1'b0, 1'b0, 16'sd4, "R5");
        for (int i = 0; i < NT - 1; i++) step(1'b0, 2'd1, 1'b0, 1'b0, 16'sd4, "R7");
        step(1'b1, 2'd1, 1'b0, 1'b0, 16'sd4, "R6");
        for (int i = 0; i < 3000; i++) begin
            logic b, a, h;
            logic [1:0] s;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = (lfsr[1:0] == 2'b00);
            a = (lfsr[6:3] == 4'hF);
            h = lfsr[8];
            s = (lfsr[12:9] == 4'h0) ? lfsr[14:13] : ref_sel;
            step(b, s, a, h, $signed(lfsr ^ 16'h5A5A), "sweep R2 R3 R4 R5 R6 R7");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule